// File: doc/BRIEF.md
# Zero-Flagged Diminished-One Translator

This block converts between a plain binary residue modulo 2^n+1 and a zero-flagged diminished-one code. The binary side is n+1 bits wide and holds a value in 0..2^n. The coded side has two parts. The first is a flag bit that is 1 only for the value zero. The second is an n-bit diminished word that holds the value minus one, or zero when the flag is set. Modulo 2^n+1 adders and multipliers work on n-bit words in this code. They read the flag instead of keeping an extra operand bit.

The block has two independent paths, and both are purely combinational. There is no clock, no register and no handshake, so every output follows its own inputs in the same cycle. The encode path adds an all-ones word to the low n input bits and feeds the zero flag in as the carry. This reduces to one XNOR per bit, with the carries taken from a logarithmic OR scan. The decode path is an incrementer that is enabled when the flag is clear, with its carries taken from a logarithmic AND scan. The width n is the `WIDTH` parameter. Binary inputs above 2^n are not checked, and their results are not defined.

Top module: `zfd_translator`

## Requirements
- R1: The encode flag `enc_zero` is 1 exactly when all n+1 bits of `bin_in` are 0.
- R2: An input value of 0 encodes to flag 1 and a diminished word of 0.
- R3: An input value of 2^n (only bit n set) encodes to flag 0 and a diminished word with all n bits set to 1.
- R4: An input value k with 1 <= k <= 2^n-1 encodes to flag 0 and a diminished word of k-1.
- R5: When `dec_zero` is 0, `bin_out` equals `dec_dim` + 1 as an (n+1)-bit value, so an all-ones diminished word decodes to 2^n.
- R6: When `dec_zero` is 1, `bin_out` equals `dec_dim` zero-extended to n+1 bits, so the canonical zero code decodes to 0.
- R7: Feeding the encode outputs into the decode inputs returns the original value for every input in 0..2^n, both with n=4 and with n=8. The result settles in the same cycle, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_in | input | WIDTH+1 | Binary residue to encode, in the range 0..2^WIDTH |
| enc_zero | output | 1 | Zero flag of the encoded value |
| enc_dim | output | WIDTH | Diminished-one word of the encoded value |
| dec_zero | input | 1 | Zero flag of the value to decode |
| dec_dim | input | WIDTH | Diminished-one word of the value to decode |
| bin_out | output | WIDTH+1 | Decoded binary residue |

## Verification
The immediate assertions are evaluated whenever the inputs change. They compare each path's bit-level output against its arithmetic meaning: a set flag forces a zero diminished word, a nonzero low part encodes to that value minus one, and the decoder either increments or passes the word through. They also check that each scan tree gives a monotone carry vector. Only the bench scenarios cover the complete round trip over the whole 0..2^n range at two widths. The bench also covers the boundary code 2^n and the decoding of non-canonical words that carry a set flag. None of these can be seen from a single path in isolation.

// File: rtl/zfd_pkg.sv
package zfd_pkg;

  typedef enum logic {
    SCAN_OR  = 1'b0,
    SCAN_AND = 1'b1
  } scan_op_e;

  function automatic int scan_levels(input int width);
    int lv;
    lv = 0;
    while ((1 << lv) < width) lv++;
    return (lv < 1) ? 1 : lv;
  endfunction

endpackage

// File: rtl/zfd_prefix_scan.sv
module zfd_prefix_scan #(
  parameter int              WIDTH = 8,
  parameter zfd_pkg::scan_op_e OP  = zfd_pkg::SCAN_OR
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [WIDTH-1:0] scan_o
);
  localparam int LEVELS = zfd_pkg::scan_levels(WIDTH);

  // Kogge-Stone style inclusive scan: stage l merges spans of 2^l
  logic [LEVELS:0][WIDTH-1:0] stage;

  assign stage[0] = vec_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int SPAN = 1 << l;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SPAN) begin : g_merge
        if (OP == zfd_pkg::SCAN_OR) begin : g_or
          assign stage[l+1][i] = stage[l][i] | stage[l][i-SPAN];
        end else begin : g_and
          assign stage[l+1][i] = stage[l][i] & stage[l][i-SPAN];
        end
      end else begin : g_pass
        assign stage[l+1][i] = stage[l][i];
      end
    end
  end

  assign scan_o = stage[LEVELS];

  // Scan outputs must be monotone along the vector and anchored at bit 0
  always_comb begin
    assert_scan_anchor_R7: assert (scan_o[0] == vec_i[0]);
    for (int i = 0; i < WIDTH - 1; i++) begin
      if (OP == zfd_pkg::SCAN_OR) begin
        assert_scan_or_mono_R7: assert (!scan_o[i] || scan_o[i+1]);
      end else begin
        assert_scan_and_mono_R7: assert (!scan_o[i+1] || scan_o[i]);
      end
    end
  end

endmodule

// File: rtl/zfd_encode.sv
module zfd_encode #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   bin_i,
  output logic             zero_o,
  output logic [WIDTH-1:0] dim_o
);
  logic [WIDTH-1:0] scan_vec;
  logic [WIDTH-1:0] carry_in;

  // Zero flag: NOR over all n+1 bits
  assign zero_o = ~(|bin_i);

  // Carry into bit i = flag OR any lower input bit (generate = x, transmit = 1)
  if (WIDTH > 1) begin : g_wide
    assign scan_vec = {bin_i[WIDTH-2:0], zero_o};
  end else begin : g_narrow
    assign scan_vec = zero_o;
  end

  zfd_prefix_scan #(
    .WIDTH (WIDTH),
    .OP    (zfd_pkg::SCAN_OR)
  ) or_scan_i (
    .vec_i  (scan_vec),
    .scan_o (carry_in)
  );

  // Sum with an all-ones addend: one XNOR per bit
  assign dim_o = ~(bin_i[WIDTH-1:0] ^ carry_in);

  always_comb begin
    if (zero_o) begin
      assert_flag_clears_dim_R2: assert (dim_o == '0);
    end
    if (bin_i[WIDTH] && (bin_i[WIDTH-1:0] == '0)) begin
      assert_top_code_R3: assert (!zero_o && (&dim_o));
    end
    if (bin_i[WIDTH-1:0] != '0) begin
      assert_minus_one_R4: assert (!zero_o && (dim_o == bin_i[WIDTH-1:0] - 1'b1));
    end
  end

endmodule

// File: rtl/zfd_decode.sv
module zfd_decode #(
  parameter int WIDTH = 8
) (
  input  logic             zero_i,
  input  logic [WIDTH-1:0] dim_i,
  output logic [WIDTH:0]   bin_o
);
  logic             inc;
  logic [WIDTH-1:0] scan_vec;
  logic [WIDTH-1:0] carry_in;

  assign inc = ~zero_i;

  // Carry into bit i = increment enable AND all lower bits set
  if (WIDTH > 1) begin : g_wide
    assign scan_vec = {dim_i[WIDTH-2:0], inc};
  end else begin : g_narrow
    assign scan_vec = inc;
  end

  zfd_prefix_scan #(
    .WIDTH (WIDTH),
    .OP    (zfd_pkg::SCAN_AND)
  ) and_scan_i (
    .vec_i  (scan_vec),
    .scan_o (carry_in)
  );

  assign bin_o[WIDTH-1:0] = dim_i ^ carry_in;
  assign bin_o[WIDTH]     = dim_i[WIDTH-1] & carry_in[WIDTH-1];

  always_comb begin
    if (!zero_i) begin
      assert_increment_R5: assert (bin_o == ({1'b0, dim_i} + 1'b1));
    end else begin
      assert_passthrough_R6: assert (bin_o == {1'b0, dim_i});
    end
    if (bin_o[WIDTH]) begin
      assert_top_only_from_ones_R5: assert (!zero_i && (&dim_i));
    end
  end

endmodule

// File: rtl/zfd_translator.sv
module zfd_translator #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   bin_in,
  output logic             enc_zero,
  output logic [WIDTH-1:0] enc_dim,
  input  logic             dec_zero,
  input  logic [WIDTH-1:0] dec_dim,
  output logic [WIDTH:0]   bin_out
);

  zfd_encode #(.WIDTH(WIDTH)) encode_i (
    .bin_i  (bin_in),
    .zero_o (enc_zero),
    .dim_o  (enc_dim)
  );

  zfd_decode #(.WIDTH(WIDTH)) decode_i (
    .zero_i (dec_zero),
    .dim_i  (dec_dim),
    .bin_o  (bin_out)
  );

endmodule

// File: tb/zfd_translator_tb_top.sv
module zfd_translator_tb_top;

  typedef struct packed {
    logic       w8;
    logic       fwd;
    logic       exp_zero;
    logic [7:0] exp_dim;
    logic [8:0] exp_bin;
    logic [3:0] req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  // n = 8 instance
  logic [8:0] bin8 = '0;
  logic       z8, tz8 = 1'b1, rz8, loop8 = 1'b1;
  logic [7:0] d8, td8 = '0, rd8;
  logic [8:0] b8;
  assign rz8 = loop8 ? z8 : tz8;
  assign rd8 = loop8 ? d8 : td8;

  zfd_translator #(.WIDTH(8)) dut_i (
    .bin_in (bin8), .enc_zero (z8), .enc_dim (d8),
    .dec_zero (rz8), .dec_dim (rd8), .bin_out (b8)
  );

  // n = 4 instance
  logic [4:0] bin4 = '0;
  logic       z4, tz4 = 1'b1, rz4, loop4 = 1'b1;
  logic [3:0] d4, td4 = '0, rd4;
  logic [4:0] b4;
  assign rz4 = loop4 ? z4 : tz4;
  assign rd4 = loop4 ? d4 : td4;

  zfd_translator #(.WIDTH(4)) dut_n4_i (
    .bin_in (bin4), .enc_zero (z4), .enc_dim (d4),
    .dec_zero (rz4), .dec_dim (rd4), .bin_out (b4)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  int    cycles = 0;
  item_t sb_q[$];

  function automatic string rtag(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Driver: encode stimulus with loopback into the decoder
  task automatic drive_fwd(input bit w8, input int v);
    item_t it;
    int    n;
    n = w8 ? 8 : 4;
    @(posedge clk);
    if (w8) begin bin8 = v[8:0]; loop8 = 1'b1; end
    else    begin bin4 = v[4:0]; loop4 = 1'b1; end
    it.w8       = w8;
    it.fwd      = 1'b1;
    it.exp_zero = (v == 0);
    it.exp_dim  = (v == 0) ? 8'd0 : 8'(v - 1);
    it.exp_bin  = 9'(v);
    it.req      = (v == 0) ? 4'd2 : ((v == (1 << n)) ? 4'd3 : 4'd4);
    sb_q.push_back(it);
  endtask

  // Driver: direct decode stimulus
  task automatic drive_rev(input bit w8, input bit zf, input int d);
    item_t it;
    @(posedge clk);
    if (w8) begin tz8 = zf; td8 = d[7:0]; loop8 = 1'b0; end
    else    begin tz4 = zf; td4 = d[3:0]; loop4 = 1'b0; end
    it.w8       = w8;
    it.fwd      = 1'b0;
    it.exp_zero = zf;
    it.exp_dim  = 8'(d);
    it.exp_bin  = zf ? 9'(d) : 9'(d + 1);
    it.req      = zf ? 4'd6 : 4'd5;
    sb_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      item_t      it;
      logic       az;
      logic [7:0] ad;
      logic [8:0] ab;
      it = sb_q.pop_front();
      if (it.w8) begin az = z8; ad = d8; ab = b8; end
      else begin az = z4; ad = {4'b0, d4}; ab = {4'b0, b4}; end
      if (it.fwd) begin
        chk(az == it.exp_zero, "R1 zero flag", int'(az), int'(it.exp_zero));
        chk(ad == it.exp_dim, rtag(it.req), int'(ad), int'(it.exp_dim));
        chk(ab == it.exp_bin, "R7 round trip", int'(ab), int'(it.exp_bin));
      end else begin
        chk(ab == it.exp_bin, rtag(it.req), int'(ab), int'(it.exp_bin));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // Reset state: all-zero inputs seen before any drive (R2)
    @(negedge clk);
    chk(z8 == 1'b1 && d8 == 8'd0, "R2 idle encode", int'({z8, d8}), 'h100);
    chk(b8 == 9'd0, "R7 idle loopback", int'(b8), 0);
    rst = 1'b0;

    // R2, R3, R4, R7: full sweep at n = 4 and n = 8
    for (int v = 0; v <= 16; v++) drive_fwd(1'b0, v);
    for (int v = 0; v <= 256; v++) drive_fwd(1'b1, v);
    // Boundary values again after large jumps
    drive_fwd(1'b1, 256);
    drive_fwd(1'b1, 0);
    drive_fwd(1'b0, 16);
    drive_fwd(1'b0, 1);

    // R5: increment when flag clear, including all-ones to 2^n
    drive_rev(1'b1, 1'b0, 0);
    drive_rev(1'b1, 1'b0, 255);
    drive_rev(1'b1, 1'b0, 127);
    drive_rev(1'b0, 1'b0, 15);
    drive_rev(1'b0, 1'b0, 6);
    // R6: flag set passes the word through
    drive_rev(1'b1, 1'b1, 0);
    drive_rev(1'b1, 1'b1, 'h5A);
    drive_rev(1'b1, 1'b1, 255);
    drive_rev(1'b0, 1'b1, 0);
    drive_rev(1'b0, 1'b1, 7);

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule